// File: doc/BRIEF.md
# Shared-Prescaler Event Timer with Watchdog

This block combines an 8-bit up-counting event timer with a watchdog, and both use one 8-bit prescaler. The timer counts either every cycle of the instruction clock (`clk`) or qualified edges of an external input pin. A per-bit inversion of that pin selects whether rising or falling edges are counted. A control byte gives the prescaler to one consumer at a time. When the timer owns it, the prescaler divides the timer's count events and the watchdog runs undivided. When the watchdog owns it, the prescaler divides the watchdog's base overflows and the timer sees every count event directly.

Count events reach the timer through a two-stage synchroniser. When the timer wraps from 0xFF to 0x00, a sticky overflow flag is set and stays set until it is cleared. The watchdog's base counter advances on a separate tick input. When the watchdog is enabled, it raises a one-cycle time-out pulse at the end of each period. A watchdog-clear command restarts the period.

Top module: `tmr_wdt_shared`

## Requirements
- R1: After reset the control byte reads 0xFF, the timer reads 0x00, the overflow flag is 0 and the time-out output is 0.
- R2: A control write stores all eight bits and takes effect from the next cycle. The fields are: bit 5 source (0 internal, 1 pin), bit 4 pin inversion (1 counts falling edges), bit 3 prescaler owner (0 timer, 1 watchdog) and bits 2..0 ratio select. Bits 7..6 are stored but have no effect here.
- R3: With the internal source and the prescaler owned by the watchdog, the timer advances by one on every cycle. Each advance arrives three clock edges after the cycle that produced the event.
- R4: With the pin source, one count event is produced for each 0-to-1 transition of (pin XOR bit 4).
- R5: With the prescaler owned by the timer, the timer advances once per 2^(sel+1) count events, for sel values 0 to 7.
- R6: The watchdog base period is 2^BASE_W ticks. With the prescaler owned by the timer, the time-out period is one base period. With it owned by the watchdog, the time-out period is 2^sel base periods. Each time-out is a single-cycle pulse.
- R7: A timer write loads the value on the next edge, zeroes the prescaler and discards count events in flight. The loaded value is held for the following cycle.
- R8: The overflow flag is set only by a 0xFF-to-0x00 advance. It stays set until the clear input is asserted, and a new overflow in the same cycle as a clear leaves the flag set.
- R9: While the watchdog enable is 0, no time-out is issued and the base count is held at zero.
- R10: A watchdog-clear restarts both the base count and the prescaler.
- R11: Changing the prescaler owner re-routes the timer and watchdog paths from the next cycle without clearing the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Control byte write strobe |
| opt_wdata | input | 8 | Control byte write data |
| opt_q | output | 8 | Control byte readback |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_q | output | 8 | Timer value |
| ext_pin | input | 1 | External count input |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdt_en | input | 1 | Watchdog enable configuration |
| wdt_tick | input | 1 | Watchdog base-counter advance |
| wdt_clr | input | 1 | Watchdog-clear command |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The bench sweeps all eight ratio codes for both prescaler owners. An off-by-one tap would show up either as the timer counting twice as fast or as the watchdog period being doubled. It toggles the pin under both polarities and watches for a design that counts the wrong edge or counts both edges. It also checks timer writes that land while events are still in the synchroniser, since a design that lets a stale event through would advance the newly loaded value early. Finally, it moves the prescaler between owners in the middle of a run, and it overlaps clear and overflow so that a clear-priority bug would drop the flag.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int CTRL_W = 8;

    typedef struct packed {
        logic       pullup_en;
        logic       irq_rise;
        logic       src_ext;
        logic       edge_inv;
        logic       pre_wdt;
        logic [2:0] ratio_sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '1;
endpackage

// File: rtl/tw_edge_src.sv
module tw_edge_src (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_inv,
    input  logic src_ext,
    output logic evt
);
    logic lvl;
    logic prev_d, prev_q;

    always_comb begin
        lvl    = pin ^ edge_inv;
        prev_d = lvl;
        evt    = src_ext ? (lvl & ~prev_q) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tw_wdt_base.sv
module tw_wdt_base #(
    parameter int BASE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic tick,
    output logic wrap
);
    localparam logic [BASE_W-1:0] ONE = 1;

    logic [BASE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (!en || clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + ONE;
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             wdt_mode,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);
    localparam int SPAN_W = PRE_W + 1;
    localparam logic [PRE_W-1:0]  ONE      = 1;
    localparam logic [SPAN_W-1:0] SPAN_ONE = 1;
    localparam logic [SEL_W:0]    SH_ONE   = 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [SEL_W:0]    shamt;
    logic [SPAN_W-1:0] span, span_m1;
    logic [PRE_W-1:0]  mask, nxt;

    always_comb begin
        shamt   = wdt_mode ? {1'b0, sel} : ({1'b0, sel} + SH_ONE);
        span    = SPAN_ONE << shamt;
        span_m1 = span - SPAN_ONE;
        mask    = span_m1[PRE_W-1:0];
        nxt     = s_q.cnt + ONE;
        s_d     = s_q;
        tap     = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (inc) begin
            s_d.cnt = nxt;
            tap     = ((nxt & mask) == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tmr_wdt_shared.sv
module tmr_wdt_shared #(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int SEL_W  = 3,
    parameter int BASE_W = 4,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_we,
    input  logic [7:0]        opt_wdata,
    output logic [7:0]        opt_q,
    input  logic              tmr_we,
    input  logic [DATA_W-1:0] tmr_wdata,
    output logic [DATA_W-1:0] tmr_q,
    input  logic              ext_pin,
    input  logic              flag_clr,
    output logic              ovf_flag,
    input  logic              wdt_en,
    input  logic              wdt_tick,
    input  logic              wdt_clr,
    output logic              wdt_timeout
);
    import tw_pkg::*;

    localparam logic [DATA_W-1:0] T_ONE = 1;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] tmr;
        logic [SYNC_N-1:0] sync;
        logic              flag;
        logic              tout;
    } top_state_t;

    top_state_t s_d, s_q;

    logic src_evt, base_wrap, pre_tap;
    logic pre_inc, pre_clr, tmr_evt, wdt_evt;
    logic [SYNC_N-1:0] sync_shift;

    tw_edge_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .edge_inv (s_q.ctrl.edge_inv),
        .src_ext  (s_q.ctrl.src_ext),
        .evt      (src_evt)
    );

    tw_wdt_base #(.BASE_W(BASE_W)) u_base (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (wdt_en),
        .clr  (wdt_clr),
        .tick (wdt_tick),
        .wrap (base_wrap)
    );

    tw_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pre_clr),
        .inc     (pre_inc),
        .wdt_mode(s_q.ctrl.pre_wdt),
        .sel     (s_q.ctrl.ratio_sel),
        .tap     (pre_tap)
    );

    generate
        if (SYNC_N == 1) begin : g_sync1
            assign sync_shift = tmr_evt;
        end else begin : g_syncn
            assign sync_shift = {s_q.sync[SYNC_N-2:0], tmr_evt};
        end
    endgenerate

    always_comb begin
        pre_clr = tmr_we | wdt_clr;
        pre_inc = s_q.ctrl.pre_wdt ? base_wrap : src_evt;
        tmr_evt = s_q.ctrl.pre_wdt ? src_evt   : pre_tap;
        wdt_evt = s_q.ctrl.pre_wdt ? pre_tap   : base_wrap;

        s_d = s_q;
        if (opt_we) s_d.ctrl = ctrl_t'(opt_wdata);

        s_d.flag = s_q.flag & ~flag_clr;
        if (tmr_we) begin
            s_d.tmr  = tmr_wdata;
            s_d.sync = '0;
        end else begin
            s_d.sync = sync_shift;
            if (s_q.sync[SYNC_N-1]) begin
                s_d.tmr = s_q.tmr + T_ONE;
                if (&s_q.tmr) s_d.flag = 1'b1;
            end
        end

        s_d.tout = wdt_evt & wdt_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl <= CTRL_RST;
            s_q.tmr  <= '0;
            s_q.sync <= '0;
            s_q.flag <= 1'b0;
            s_q.tout <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign opt_q       = s_q.ctrl;
    assign tmr_q       = s_q.tmr;
    assign ovf_flag    = s_q.flag;
    assign wdt_timeout = s_q.tout;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              opt_we,
    input logic [7:0]        opt_wdata,
    input logic [7:0]        opt_q,
    input logic              tmr_we,
    input logic [DATA_W-1:0] tmr_wdata,
    input logic [DATA_W-1:0] tmr_q,
    input logic              flag_clr,
    input logic              ovf_flag,
    input logic              wdt_en,
    input logic              wdt_timeout
);
    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opt_we |=> opt_q == $past(opt_wdata));

    // R7
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> tmr_q == $past(tmr_wdata));

    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmr_we) && !tmr_we) |=> $stable(tmr_q));

    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(tmr_q) == '1 && tmr_q == '0));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    // R9
    wdt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> !wdt_timeout);

    // R6
    tout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);
endmodule

bind tmr_wdt_shared tw_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opt_we     (opt_we),
    .opt_wdata  (opt_wdata),
    .opt_q      (opt_q),
    .tmr_we     (tmr_we),
    .tmr_wdata  (tmr_wdata),
    .tmr_q      (tmr_q),
    .flag_clr   (flag_clr),
    .ovf_flag   (ovf_flag),
    .wdt_en     (wdt_en),
    .wdt_timeout(wdt_timeout)
);

// File: tb/tmr_wdt_shared_bench.sv
`timescale 1ns/1ps
module tmr_wdt_shared_bench;
    localparam int BASE_W = 4;
    localparam int BASE_N = 1 << BASE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic opt_we = 1'b0;
    logic [7:0] opt_wdata = 8'h00;
    logic [7:0] opt_q;
    logic tmr_we = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic [7:0] tmr_q;
    logic ext_pin = 1'b0;
    logic flag_clr = 1'b0;
    logic ovf_flag;
    logic wdt_en = 1'b0;
    logic wdt_tick = 1'b0;
    logic wdt_clr = 1'b0;
    logic wdt_timeout;

    always #2.5 clk = ~clk;

    tmr_wdt_shared #(.BASE_W(BASE_W)) u_tmr_wdt_shared (
        .clk(clk), .rst_n(rst_n),
        .opt_we(opt_we), .opt_wdata(opt_wdata), .opt_q(opt_q),
        .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
        .ext_pin(ext_pin), .flag_clr(flag_clr), .ovf_flag(ovf_flag),
        .wdt_en(wdt_en), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
        .wdt_timeout(wdt_timeout)
    );

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit running = 1'b0;
    bit done = 1'b0;
    int n_tout = 0;

    // behavioural reference state
    int m_opt = 255, m_tmr = 0, m_flag = 0, m_to = 0;
    int m_pre = 0, m_base = 0, m_prev = 1;
    int pipe[$] = '{0, 0};

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        int px, sp, bo, asg, ps, ratio, pinc, pout, tinc, wraw, outv, setf;
        if (!rst_n) begin
            m_opt = 255; m_tmr = 0; m_flag = 0; m_to = 0;
            m_pre = 0; m_base = 0; m_prev = 1;
            pipe = '{0, 0};
        end else begin
            px = int'(ext_pin) ^ ((m_opt >> 4) & 1);
            sp = ((m_opt >> 5) & 1) != 0 ? int'(px == 1 && m_prev == 0) : 1;
            m_prev = px;
            bo = 0;
            if (!wdt_en || wdt_clr) m_base = 0;
            else if (wdt_tick) begin
                bo = int'(m_base == BASE_N - 1);
                m_base = (m_base + 1) % BASE_N;
            end
            asg = (m_opt >> 3) & 1;
            ps = m_opt & 7;
            ratio = asg != 0 ? (1 << ps) : (2 << ps);
            pinc = asg != 0 ? bo : sp;
            pout = 0;
            if (tmr_we || wdt_clr) m_pre = 0;
            else if (pinc != 0) begin
                m_pre = (m_pre + 1) % 256;
                pout = int'(m_pre % ratio == 0);
            end
            tinc = asg != 0 ? sp : pout;
            wraw = asg != 0 ? pout : bo;
            outv = pipe.pop_front();
            setf = 0;
            if (tmr_we) begin
                pipe.delete();
                pipe.push_back(0);
                pipe.push_back(0);
                m_tmr = int'(tmr_wdata);
            end else begin
                pipe.push_back(tinc);
                if (outv != 0) begin
                    if (m_tmr == 255) begin m_tmr = 0; setf = 1; end
                    else m_tmr = m_tmr + 1;
                end
            end
            m_flag = int'(setf != 0 || (m_flag != 0 && !flag_clr));
            m_to = int'(wraw != 0 && wdt_en);
            if (opt_we) m_opt = int'(opt_wdata);
        end
    end

    always @(negedge clk) begin
        if (running && !done) begin
            chk(cur_req, "ctrl", int'(opt_q), m_opt);
            chk(cur_req, "timer", int'(tmr_q), m_tmr);
            chk(cur_req, "flag", int'(ovf_flag), m_flag);
            chk(cur_req, "timeout", int'(wdt_timeout), m_to);
            if (wdt_timeout) n_tout++;
        end
    end

    // stimulus pattern generators
    int cyc = 0;
    int pin_period = 0;
    int tick_period = 0;
    always begin
        @(negedge clk);
        #1;
        cyc++;
        if (pin_period > 0 && cyc % pin_period == 0) ext_pin = ~ext_pin;
        wdt_tick = (tick_period > 0) && (cyc % tick_period == 0);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_opt(logic [7:0] v);
        @(negedge clk); #1;
        opt_we = 1'b1; opt_wdata = v;
        @(negedge clk); #1;
        opt_we = 1'b0;
    endtask

    task automatic wr_tmr(logic [7:0] v);
        @(negedge clk); #1;
        tmr_we = 1'b1; tmr_wdata = v;
        @(negedge clk); #1;
        tmr_we = 1'b0;
    endtask

    task automatic wdt_kick();
        @(negedge clk); #1;
        wdt_clr = 1'b1;
        @(negedge clk); #1;
        wdt_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        running = 1'b1;
        cur_req = "R1";
        idle(4);
        chk("R1", "reset ctrl", int'(opt_q), 255);
        chk("R1", "reset timer", int'(tmr_q), 0);
        chk("R1", "reset flag", int'(ovf_flag), 0);
        chk("R1", "reset timeout", int'(wdt_timeout), 0);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R2";
        wr_opt(8'h5A);
        idle(1);
        chk("R2", "ctrl readback", int'(opt_q), 8'h5A);
        wr_opt(8'hC3);
        idle(2);

        cur_req = "R3";
        wr_opt(8'h08);
        wr_tmr(8'h00);
        idle(3);
        chk("R3", "first advance", int'(tmr_q), 1);
        idle(40);

        cur_req = "R5";
        for (int ps = 0; ps < 8; ps++) begin
            wr_opt(8'(ps));
            wr_tmr(8'h00);
            idle((2 << ps) * 2 + 6);
        end

        cur_req = "R8";
        wr_opt(8'h08);
        wr_tmr(8'hFA);
        idle(12);
        chk("R8", "flag after wrap", int'(ovf_flag), 1);
        flag_clr = 1'b1;
        idle(1);
        flag_clr = 1'b0;
        idle(2);
        chk("R8", "flag cleared", int'(ovf_flag), 0);
        flag_clr = 1'b1;
        wr_tmr(8'hFD);
        idle(10);
        flag_clr = 1'b0;
        idle(4);

        cur_req = "R4";
        pin_period = 3;
        wr_opt(8'h28);
        wr_tmr(8'h00);
        idle(40);
        wr_opt(8'h38);
        idle(40);
        wr_opt(8'h21);
        wr_tmr(8'h00);
        idle(80);
        wr_opt(8'h31);
        idle(80);
        pin_period = 0;

        cur_req = "R6";
        wdt_en = 1'b1;
        tick_period = 2;
        wr_opt(8'h08);
        wdt_kick();
        n_tout = 0;
        idle(BASE_N * 2 * 4 + 2);
        chk("R6", "timeouts in four periods", n_tout, 4);
        for (int ps = 1; ps < 4; ps++) begin
            wr_opt(8'h08 | 8'(ps));
            wdt_kick();
            idle(BASE_N * 2 * (1 << ps) * 2 + 8);
        end
        wr_opt(8'h00);
        wdt_kick();
        idle(100);

        cur_req = "R10";
        wr_opt(8'h09);
        wdt_kick();
        n_tout = 0;
        for (int k = 0; k < 5; k++) begin
            idle(50);
            wdt_kick();
        end
        chk("R10", "no timeout while kicked", n_tout, 0);
        idle(100);

        cur_req = "R9";
        wdt_en = 1'b0;
        n_tout = 0;
        idle(200);
        chk("R9", "disabled timeouts", n_tout, 0);
        wdt_en = 1'b1;

        cur_req = "R11";
        wr_opt(8'h01);
        wr_tmr(8'h00);
        idle(30);
        wr_opt(8'h09);
        idle(30);
        wr_opt(8'h01);
        idle(30);
        wr_opt(8'h08);
        idle(60);

        cur_req = "R7";
        wr_opt(8'h08);
        idle(5);
        wr_tmr(8'h40);
        chk("R7", "loaded", int'(tmr_q), 8'h40);
        idle(1);
        chk("R7", "held", int'(tmr_q), 8'h40);
        wr_tmr(8'h80);
        wr_tmr(8'h90);
        idle(10);

        idle(2);
        finish_run();
    end
endmodule